// File: doc/BRIEF.md
# Power Event Arbiter With Long-Press

This block decides when the application processor should be switched on or off. It samples its inputs once per millisecond tick. The sequencer that performs the actual power transitions tells it through `cpu_on` whether the processor is currently up.

While the processor is off, each tick runs a power-on check. The sources are tried in a fixed priority order, and the winner is reported as a one-cycle event carrying a 3-bit reason code. While the processor is on, each tick runs a power-off check instead. During the on state the block also does three things:
- It copies the power button onto the PMIC power-on strobe.
- It times a long press of the button.
- It drives a keyboard-scan disable that follows the button.

The auto-power-on, processor-off, software-on and software-off conditions are latched from one-cycle set strobes. A rising edge of the lid input latches the lid flag. Each latched flag stays pending until the block consumes it.

Top module: `pwr_event_arbiter`

## Requirements
- R1: After reset, on_evt, off_evt, pmic_pwron and kbd_scan_dis are 0 and both reason codes are 0.
- R2: On a tick with cpu_on low, the first true condition in this order gives a power-on event with the code shown:
  - pgood high: code 1
  - auto flag set: code 2
  - lid flag set: code 3
  - btn_pressed high: code 4
  - software-on flag set: code 5
- R3: If pgood is high and the processor-off flag is set at an off-state tick, that tick gives no event. The processor-off flag is cleared by every off-state tick.
- R4: Reporting code 1 or code 2 clears the auto flag. Code 3 clears the lid flag and code 5 clears the software-on flag. The button is not latched.
- R5: Only a 0-to-1 change of lid_open sets the lid flag, and a lid close has no effect. Any power-off event clears the lid flag.
- R6: At an on-state tick, pmic_pwron becomes 1 if the button is pressed and 0 if it is not. It is forced to 0 in the cycle after cpu_on is low.
- R7: If the button stays pressed, the long-press timer gives power-off code 2 at the LONG_TICKS-th tick after the first pressed tick. It fires only once per press. A release tick cancels the timer, and the next press starts a fresh count.
- R8: A pending software-off request gives power-off code 4 at the first on-state tick with the button released, and the request is then cleared. While the button is held, the request stays pending.
- R9: At an on-state tick with pgood low, power-off code 3 is given unless code 4 or code 2 applies at that tick.
- R10: kbd_scan_dis takes the button level at each on-state tick and is 0 while cpu_on is low.
- R11: An event output is a one-cycle pulse in the cycle after a tick, and its code is 0 in every cycle without an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle sample strobe, once per millisecond |
| cpu_on | input | 1 | Processor is in the on state (from the sequencer) |
| pgood | input | 1 | PMIC power-good |
| btn_pressed | input | 1 | Debounced power button, 1 = pressed |
| lid_open | input | 1 | Lid level, 1 = open |
| auto_on_set | input | 1 | Strobe that sets the auto-power-on flag |
| ap_off_set | input | 1 | Strobe that sets the processor-off flag |
| sw_on_req | input | 1 | Strobe for a software power-on request |
| sw_off_req | input | 1 | Strobe for a software power-off request |
| on_evt | output | 1 | Power-on event pulse |
| on_code | output | 3 | Power-on reason code, 0 when no event |
| off_evt | output | 1 | Power-off event pulse |
| off_code | output | 3 | Power-off reason code, 0 when no event |
| pmic_pwron | output | 1 | PMIC power-on strobe, active high |
| kbd_scan_dis | output | 1 | Keyboard scanning disabled |

## Verification
The pulse-shape assertions assume that tick is high for a single cycle, with at least one low cycle between ticks.

The reason-code assertions assume that pgood, btn_pressed and cpu_on are steady across the clock edge that ends a tick cycle.

The bench drives every input at the falling edge and raises tick for exactly one cycle at a time. It changes cpu_on, pgood and the button only between ticks.

// File: rtl/pwr_event_arbiter.sv
module pwr_event_arbiter #(
  parameter int LONG_TICKS = 10200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cpu_on,
  input  logic       pgood,
  input  logic       btn_pressed,
  input  logic       lid_open,
  input  logic       auto_on_set,
  input  logic       ap_off_set,
  input  logic       sw_on_req,
  input  logic       sw_off_req,
  output logic       on_evt,
  output logic [2:0] on_code,
  output logic       off_evt,
  output logic [2:0] off_code,
  output logic       pmic_pwron,
  output logic       kbd_scan_dis
);
  localparam int CW = $clog2(LONG_TICKS + 1);

  logic          lid_q, lid_f, auto_f, apoff_f, swon_f, swoff_f;
  logic          held, armed;
  logic [CW-1:0] cnt;
  logic [2:0]    on_n, off_n;
  logic          chk_off, chk_on, lp_fire, req_off, pg_loss;

  assign chk_off = tick && !cpu_on;
  assign chk_on  = tick && cpu_on;
  assign lp_fire = chk_on && btn_pressed && held && armed && (cnt == CW'(LONG_TICKS));
  assign req_off = chk_on && !btn_pressed && swoff_f;
  assign pg_loss = chk_on && !pgood;

  always_comb begin
    on_n = 3'd0;
    if (chk_off) begin
      if (pgood)            on_n = apoff_f ? 3'd0 : 3'd1;
      else if (auto_f)      on_n = 3'd2;
      else if (lid_f)       on_n = 3'd3;
      else if (btn_pressed) on_n = 3'd4;
      else if (swon_f)      on_n = 3'd5;
    end
  end

  assign off_n = req_off ? 3'd4 : lp_fire ? 3'd2 : pg_loss ? 3'd3 : 3'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_evt <= 1'b0; on_code <= '0; off_evt <= 1'b0; off_code <= '0;
      pmic_pwron <= 1'b0; kbd_scan_dis <= 1'b0;
      lid_q <= 1'b0; lid_f <= 1'b0; auto_f <= 1'b0; apoff_f <= 1'b0;
      swon_f <= 1'b0; swoff_f <= 1'b0;
      held <= 1'b0; armed <= 1'b0; cnt <= '0;
    end else begin
      on_evt   <= (on_n != 3'd0);
      on_code  <= on_n;
      off_evt  <= (off_n != 3'd0);
      off_code <= off_n;
      lid_q    <= lid_open;

      if (chk_off) apoff_f <= 1'b0;
      if (on_n == 3'd1 || on_n == 3'd2) auto_f <= 1'b0;
      if (on_n == 3'd3 || off_n != 3'd0) lid_f <= 1'b0;
      if (on_n == 3'd5) swon_f <= 1'b0;
      if (req_off) swoff_f <= 1'b0;

      if (!cpu_on) begin
        pmic_pwron <= 1'b0; kbd_scan_dis <= 1'b0;
        held <= 1'b0; armed <= 1'b0; cnt <= '0;
      end else if (tick) begin
        kbd_scan_dis <= btn_pressed;
        pmic_pwron   <= btn_pressed;
        held         <= btn_pressed;
        if (!btn_pressed) begin
          armed <= 1'b0;
        end else if (!held) begin
          armed <= 1'b1;
          cnt   <= CW'(1);
        end else if (lp_fire) begin
          armed <= 1'b0;
        end else if (armed) begin
          cnt <= cnt + CW'(1);
        end
      end

      if (lid_open && !lid_q) lid_f   <= 1'b1;
      if (auto_on_set)        auto_f  <= 1'b1;
      if (ap_off_set)         apoff_f <= 1'b1;
      if (sw_on_req)          swon_f  <= 1'b1;
      if (sw_off_req)         swoff_f <= 1'b1;
    end
  end

  a_r11_on_pulse: assert property (@(posedge clk) disable iff (!rst_n) on_evt |=> !on_evt);
  a_r11_off_pulse: assert property (@(posedge clk) disable iff (!rst_n) off_evt |=> !off_evt);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n) !(on_evt && off_evt));
  a_r2_on_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    on_evt |-> ($past(tick) && !$past(cpu_on)));
  a_r2_code1_pgood: assert property (@(posedge clk) disable iff (!rst_n)
    (on_code == 3'd1) |-> $past(pgood));
  a_r6_pwron_on: assert property (@(posedge clk) disable iff (!rst_n)
    pmic_pwron |-> $past(cpu_on));
  a_r7_long_btn: assert property (@(posedge clk) disable iff (!rst_n)
    (off_code == 3'd2) |-> $past(btn_pressed));
  a_r8_req_released: assert property (@(posedge clk) disable iff (!rst_n)
    (off_code == 3'd4) |-> !$past(btn_pressed));
  a_r9_pg_low: assert property (@(posedge clk) disable iff (!rst_n)
    (off_code == 3'd3) |-> !$past(pgood));
endmodule

// File: tb/pwr_event_arbiter_bench.sv
module pwr_event_arbiter_bench;
  localparam int LT = 6;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cpu_on = 1'b0, pgood = 1'b0;
  logic btn = 1'b0, lid = 1'b0, auto_s = 1'b0, apoff_s = 1'b0, swon = 1'b0, swoff = 1'b0;
  logic on_evt, off_evt, pwron, kbd;
  logic [2:0] on_code, off_code;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  pwr_event_arbiter #(.LONG_TICKS(LT)) u_pwr_event_arbiter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cpu_on(cpu_on), .pgood(pgood),
    .btn_pressed(btn), .lid_open(lid), .auto_on_set(auto_s), .ap_off_set(apoff_s),
    .sw_on_req(swon), .sw_off_req(swoff), .on_evt(on_evt), .on_code(on_code),
    .off_evt(off_evt), .off_code(off_code), .pmic_pwron(pwron), .kbd_scan_dis(kbd));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 on_evt", on_evt, 0); chk("R1 off_evt", off_evt, 0);
    chk("R1 on_code", on_code, 0); chk("R1 off_code", off_code, 0);
    chk("R1 pwron", pwron, 0); chk("R1 kbd", kbd, 0);
  endtask

  task automatic t_priority();
    pulse(auto_s); pulse(swon);
    @(negedge clk) lid = 1'b1; btn = 1'b1;
    do_tick(); chk("R2 auto code", on_code, 2); chk("R11 evt", on_evt, 1);
    @(negedge clk) chk("R11 pulse one cycle", on_evt, 0);
    chk("R11 code zero", on_code, 0);
    do_tick(); chk("R2 lid code", on_code, 3);
    do_tick(); chk("R2 btn code", on_code, 4);
    do_tick(); chk("R4 btn not latched, still 4", on_code, 4);
    @(negedge clk) btn = 1'b0;
    do_tick(); chk("R2 swon code", on_code, 5);
    do_tick(); chk("R4 swon cleared", on_evt, 0);
    @(negedge clk) pgood = 1'b1;
    do_tick(); chk("R2 pgood code", on_code, 1);
    @(negedge clk) pgood = 1'b0;
  endtask

  task automatic t_apoff();
    pulse(apoff_s); pulse(auto_s);
    @(negedge clk) pgood = 1'b1;
    do_tick(); chk("R3 apoff blocks", on_evt, 0);
    do_tick(); chk("R3 apoff cleared", on_code, 1);
    @(negedge clk) pgood = 1'b0;
    do_tick(); chk("R4 auto cleared by code1", on_evt, 0);
    @(negedge clk) lid = 1'b0;
    do_tick(); chk("R5 lid close ignored", on_evt, 0);
  endtask

  task automatic t_long_press();
    @(negedge clk) cpu_on = 1'b1; pgood = 1'b1; btn = 1'b1;
    do_tick();
    chk("R6 pwron pressed", pwron, 1); chk("R10 kbd held", kbd, 1);
    chk("R7 no early", off_evt, 0);
    for (int i = 1; i < LT; i++) begin
      do_tick(); chk("R7 not yet", off_evt, 0);
    end
    do_tick(); chk("R7 long press code", off_code, 2);
    do_tick(); chk("R7 once per press", off_evt, 0);
    @(negedge clk) btn = 1'b0;
    do_tick(); chk("R6 pwron released", pwron, 0); chk("R10 kbd released", kbd, 0);
    @(negedge clk) btn = 1'b1;
    do_tick();
    for (int i = 1; i < LT; i++) do_tick();
    @(negedge clk) btn = 1'b0;
    do_tick(); chk("R7 release cancels", off_evt, 0);
    @(negedge clk) btn = 1'b1;
    do_tick();
    for (int i = 1; i < LT; i++) begin
      do_tick(); chk("R7 fresh count", off_evt, 0);
    end
    @(negedge clk) cpu_on = 1'b0;
    @(negedge clk) chk("R6 forced low when off", pwron, 0);
    chk("R10 kbd low when off", kbd, 0);
    @(negedge clk) btn = 1'b0; pgood = 1'b0;
  endtask

  task automatic t_off_sources();
    @(negedge clk) cpu_on = 1'b1; pgood = 1'b1; btn = 1'b1;
    pulse(swoff);
    do_tick(); chk("R8 pending while held", off_evt, 0);
    @(negedge clk) btn = 1'b0;
    do_tick(); chk("R8 sw off code", off_code, 4);
    do_tick(); chk("R8 request cleared", off_evt, 0);
    @(negedge clk) lid = 1'b1;
    @(negedge clk) pgood = 1'b0;
    do_tick(); chk("R9 pgood loss code", off_code, 3);
    @(negedge clk) cpu_on = 1'b0;
    do_tick(); chk("R5 lid cleared by off event", on_evt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_priority();
    t_apoff();
    t_long_press();
    t_off_sources();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule